// File: doc/BRIEF.md
# EDID Replication Start-Up Sequencer

This block runs the start-up of a four-port display switch that keeps a local copy of the display identification data (EDID). When a source first appears, or when the local supply is present, it fetches every byte of an external serial EEPROM through a simple request/acknowledge read port and stores it in a 256-byte on-chip memory. It then makes a second pass over the memory to check the modulo-256 sum of each 128-byte block and to find the source physical address field in the extension block. Only after that does it release the hot-plug lines of all four ports and serve reads at the fixed EDID device address.

A mode register lets an external controller take the memory over instead of the EEPROM. Writing 0x01 parks the sequencer and opens a write port into the memory; writing 0x00 hands control back, which triggers the check pass and then the ready state without any EEPROM traffic. An enable pin switches the whole feature off. A restart pin reruns the sequence, but only while the local supply is present. An EEPROM that stops answering is caught by a timeout that raises an error flag and keeps the hot-plug lines low.

Top module: `edid_boot_seq`

## Requirements
- R1: From the idle state, with `repl_en` high, the mode register at 0x00 and no error, an EEPROM copy starts when `local_pwr` or `src_det` is high; while both are low `ee_req` stays low.
- R2: Exactly one EEPROM byte request is outstanding at a time: `ee_req` stays high with a stable `ee_addr` until `ee_ack`. Addresses run upward from 0 to 255, and the byte on `ee_data` at each acknowledge is stored at that address.
- R3: All four `hpd` bits are 0 from power-on reset, during the copy and during the check pass. They are 4'hF exactly while `edid_ready` is 1.
- R4: After a load, `blk_ok[0]` is 1 if and only if the modulo-256 sum of bytes 0..127 is zero. `blk_ok[1]` does the same for bytes 128..255.
- R5: After a load, `pa_found` is 1 and `pa_ptr` holds the address just after the first byte sequence 0x03, 0x0C, 0x00 that lies wholly within bytes 128..255. A sequence in bytes 0..127 is ignored, and with no match `pa_found` and `pa_ptr` are 0.
- R6: `rd_data` returns the stored byte at `rd_addr` when `edid_ready` is 1 and `rd_dev` equals 0xA0. Otherwise it returns 0xFF.
- R7: If `ee_ack` does not arrive within `TMO_CYC` cycles of a request, `ee_err` goes to 1, `ee_req` drops, and `hpd` stays 0 with `edid_ready` at 0 until a restart.
- R8: With `repl_en` low, `hpd` is 4'hF, `edid_ready` and `ee_req` are 0 and `rd_data` is 0xFF. Raising `repl_en` again reruns the full sequence.
- R9: A mode write of 0x01 stops the EEPROM copy, holds `hpd` at 0 and accepts `ext_we` writes. A later write of 0x00 runs the check pass and reaches ready without any EEPROM request. Mode writes of any other value have no effect.
- R10: `restart_n` low while `local_pwr` is high returns the sequencer to idle and clears `ee_err`, and the sequence reruns after release. While `local_pwr` is low, `restart_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| restart_n | input | 1 | Sequence restart pin, active low, honoured only with local power |
| local_pwr | input | 1 | Local system supply present |
| src_det | input | 1 | A source supply has been detected (first hot-plug event) |
| repl_en | input | 1 | Replication feature enable |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| ee_req | output | 1 | EEPROM byte read request |
| ee_addr | output | AW | EEPROM byte address |
| ee_ack | input | 1 | EEPROM read acknowledge, one cycle |
| ee_data | input | 8 | EEPROM read byte, valid with `ee_ack` |
| ext_we | input | 1 | External controller memory write strobe |
| ext_addr | input | AW | External controller write address |
| ext_wdata | input | 8 | External controller write byte |
| rd_dev | input | 8 | Device address of a source read |
| rd_addr | input | AW | Byte address of a source read |
| rd_data | output | 8 | Source read data |
| hpd | output | 4 | Hot-plug outputs of the four ports, 1 = asserted high |
| edid_ready | output | 1 | Memory contents are valid and being served |
| ee_err | output | 1 | EEPROM acknowledge timeout occurred |
| blk_ok | output | 2 | Per 128-byte block checksum valid |
| pa_found | output | 1 | Physical address field located |
| pa_ptr | output | AW | Address of the physical address field |

## Verification
The bench goes after the edges of the address search: a pattern placed in the first block, one ending just before the last checksum byte, and none at all. A design that skipped the block limit, or that searched too late or too early, would report a wrong or phantom pointer. Each block is given a deliberately bad sum so that swapped or merged block checks show up in `blk_ok`. It also drives a restart with the local supply off, a disable in the ready state, odd mode values and a silent EEPROM. A design that got these wrong would drop ready, leave the hot-plug lines low, answer reads while disabled, or hang without raising the error flag. The hand-back from external load is checked for stray EEPROM requests.

// File: rtl/edid_boot_seq.sv
module edid_boot_seq #(
  parameter int AW = 8,
  parameter int TMO_CYC = 64,
  parameter logic [7:0] DEV_ADDR = 8'hA0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          restart_n,
  input  logic          local_pwr,
  input  logic          src_det,
  input  logic          repl_en,
  input  logic          mode_wr,
  input  logic [7:0]    mode_wdata,
  output logic          ee_req,
  output logic [AW-1:0] ee_addr,
  input  logic          ee_ack,
  input  logic [7:0]    ee_data,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [7:0]    ext_wdata,
  input  logic [7:0]    rd_dev,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [3:0]    hpd,
  output logic          edid_ready,
  output logic          ee_err,
  output logic [1:0]    blk_ok,
  output logic          pa_found,
  output logic [AW-1:0] pa_ptr
);
  localparam int DEPTH = 1 << AW;
  localparam int TMW = $clog2(TMO_CYC + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [2:0] {IDLE, COPY, CHECK, READY, EXT_LOAD} st_t;

  st_t            st;
  logic [7:0]     mem [DEPTH];
  logic [AW-1:0]  idx;
  logic [TMW-1:0] tmo;
  logic           ext_mode;
  logic [7:0]     s0, s1, p1, p2;

  wire       restart  = !restart_n && local_pwr;
  wire       mode_set = mode_wr && (mode_wdata == 8'h01);
  wire       mode_clr = mode_wr && (mode_wdata == 8'h00);
  wire       ext_nx   = mode_set ? 1'b1 : (mode_clr ? 1'b0 : ext_mode);
  wire [7:0] cur      = mem[idx];
  wire       oui_hit  = idx[AW-1] && (idx[AW-2:0] > 1) &&
                        (p2 == 8'h03) && (p1 == 8'h0C) && (cur == 8'h00);

  assign ee_req     = (st == COPY) && repl_en;
  assign ee_addr    = idx;
  assign edid_ready = (st == READY) && repl_en;
  assign hpd        = !repl_en ? 4'hF : {4{st == READY}};
  assign rd_data    = (edid_ready && rd_dev == DEV_ADDR) ? mem[rd_addr] : 8'hFF;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) ext_mode <= 1'b0;
    else        ext_mode <= ext_nx;

  always_ff @(posedge clk)
    if (st == COPY && ee_ack && repl_en && !restart) mem[idx] <= ee_data;
    else if (st == EXT_LOAD && ext_we)                mem[ext_addr] <= ext_wdata;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= IDLE; idx <= '0; tmo <= '0; ee_err <= 1'b0;
      s0 <= '0; s1 <= '0; p1 <= '0; p2 <= '0;
      blk_ok <= '0; pa_found <= 1'b0; pa_ptr <= '0;
    end else if (!repl_en || restart) begin
      st <= IDLE; idx <= '0; tmo <= '0; ee_err <= 1'b0;
      blk_ok <= '0; pa_found <= 1'b0; pa_ptr <= '0;
    end else begin
      case (st)
        IDLE:
          if (ext_nx) st <= EXT_LOAD;
          else if (!ee_err && (local_pwr || src_det)) begin
            st <= COPY; idx <= '0; tmo <= '0;
          end
        COPY:
          if (ext_nx) st <= EXT_LOAD;
          else if (ee_ack) begin
            idx <= idx + 1'b1;
            tmo <= '0;
            if (idx == LAST) begin
              st <= CHECK;
              s0 <= '0; s1 <= '0; p1 <= '0; p2 <= '0;
              blk_ok <= '0; pa_found <= 1'b0; pa_ptr <= '0;
            end
          end else if (tmo == TMW'(TMO_CYC - 1)) begin
            ee_err <= 1'b1;
            st <= IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        CHECK:
          if (ext_nx) st <= EXT_LOAD;
          else begin
            if (!idx[AW-1]) s0 <= s0 + cur;
            else            s1 <= s1 + cur;
            p2 <= p1;
            p1 <= cur;
            if (oui_hit && !pa_found) begin
              pa_found <= 1'b1;
              pa_ptr   <= idx + 1'b1;
            end
            idx <= idx + 1'b1;
            if (idx == LAST) begin
              blk_ok <= {8'(s1 + cur) == 8'h00, s0 == 8'h00};
              st <= READY;
            end
          end
        READY:
          if (ext_nx) st <= EXT_LOAD;
        EXT_LOAD:
          if (!ext_nx) begin
            st <= CHECK; idx <= '0;
            s0 <= '0; s1 <= '0; p1 <= '0; p2 <= '0;
            blk_ok <= '0; pa_found <= 1'b0; pa_ptr <= '0;
          end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module edid_boot_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          restart_n,
  input logic          local_pwr,
  input logic          repl_en,
  input logic          mode_wr,
  input logic          ee_req,
  input logic          ee_ack,
  input logic [AW-1:0] ee_addr,
  input logic [3:0]    hpd,
  input logic          edid_ready,
  input logic          ee_err,
  input logic [7:0]    rd_data
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ee_req && !ee_ack && repl_en && restart_n && !mode_wr) |=>
      ((ee_req && $stable(ee_addr)) || ee_err));

  // R3
  hpd_low_copy_chk: assert property (@(posedge clk) disable iff (!por_n)
    ee_req |-> (hpd == 4'h0));

  // R3
  hpd_high_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
    edid_ready |-> (hpd == 4'hF));

  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !edid_ready |-> (rd_data == 8'hFF));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ee_err && repl_en) |-> (hpd == 4'h0 && !edid_ready && !ee_req));

  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (!por_n)
    !repl_en |-> (hpd == 4'hF && !edid_ready && !ee_req));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (edid_ready && !restart_n && !local_pwr && repl_en && !mode_wr) |=> edid_ready);

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!restart_n && local_pwr) |=> (!edid_ready && !ee_err));
endmodule

bind edid_boot_seq edid_boot_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_edid_boot_seq.sv
`timescale 1ns/1ps
module test_edid_boot_seq;
  localparam int AW = 8;
  localparam int TMO = 64;
  localparam int LAT = 2;
  // {seed[28:21], fix0[20], fix1[19], pa_pos[18:11], exp_ok[10:9], exp_found[8], exp_ptr[7:0]}
  localparam logic [28:0] VEC [5] = '{
    {8'd5,  1'b1, 1'b1, 8'd150, 2'b11, 1'b1, 8'd153},
    {8'd3,  1'b1, 1'b0, 8'd200, 2'b01, 1'b1, 8'd203},
    {8'd7,  1'b0, 1'b1, 8'd40,  2'b10, 1'b0, 8'd0},
    {8'd11, 1'b0, 1'b0, 8'd0,   2'b00, 1'b0, 8'd0},
    {8'd13, 1'b1, 1'b1, 8'd252, 2'b11, 1'b1, 8'd255}
  };

  logic clk = 0;
  logic por_n = 0, restart_n = 1, local_pwr = 0, src_det = 0, repl_en = 1;
  logic mode_wr = 0; logic [7:0] mode_wdata = 0;
  logic ee_req, ee_ack = 0; logic [AW-1:0] ee_addr; logic [7:0] ee_data = 0;
  logic ext_we = 0; logic [AW-1:0] ext_addr = 0; logic [7:0] ext_wdata = 0;
  logic [7:0] rd_dev = 8'hA0; logic [AW-1:0] rd_addr = 0; logic [7:0] rd_data;
  logic [3:0] hpd; logic edid_ready, ee_err, pa_found; logic [1:0] blk_ok; logic [AW-1:0] pa_ptr;

  int tests = 0, fails = 0;
  logic [7:0] eimg [256];
  logic ee_dead = 0;
  int lat_cnt = 0, exp_next = 0, seq_bad = 0, acks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edid_boot_seq #(.AW(AW), .TMO_CYC(TMO)) i_edid_boot_seq (.*);

  always @(negedge clk) begin
    if (!ee_req) begin lat_cnt = 0; ee_ack <= 0; end
    else if (ee_ack) begin ee_ack <= 0; lat_cnt = 0; end
    else if (!ee_dead) begin
      if (lat_cnt == LAT) begin
        ee_ack <= 1; ee_data <= eimg[ee_addr];
        if (int'(ee_addr) != exp_next) seq_bad++;
        exp_next++; acks++; lat_cnt = 0;
      end else lat_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic build(input logic [7:0] seed, input bit f0, input bit f1, input int pos);
    logic [7:0] s;
    for (int a = 0; a < 256; a++) eimg[a] = 8'(a * seed + 7);
    if (pos != 0) begin eimg[pos] = 8'h03; eimg[pos+1] = 8'h0C; eimg[pos+2] = 8'h00; end
    s = 0; for (int a = 0; a < 127; a++) s += eimg[a];
    eimg[127] = f0 ? 8'(-s) : 8'(1 - s);
    s = 0; for (int a = 128; a < 255; a++) s += eimg[a];
    eimg[255] = f1 ? 8'(-s) : 8'(1 - s);
  endtask

  task automatic wait_ready(input int max);
    for (int i = 0; i < max && !edid_ready; i++) @(negedge clk);
  endtask

  task automatic restart();
    exp_next = 0; seq_bad = 0; acks = 0;
    restart_n = 0; @(negedge clk); @(negedge clk); restart_n = 1;
  endtask

  task automatic mode(input logic [7:0] v);
    mode_wr = 1; mode_wdata = v; @(negedge clk); mode_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    build(8'd5, 1, 1, 150);
    repeat (3) @(negedge clk);
    por_n = 1;
    repeat (20) @(negedge clk);
    // reset state and R1 hold-off
    chk(hpd == 4'h0, "R3 reset hpd", hpd, 0);
    chk(!edid_ready, "R3 reset ready", edid_ready, 0);
    chk(!ee_req, "R1 no start without supply", ee_req, 0);
    chk(rd_data == 8'hFF, "R6 not ready read", rd_data, 8'hFF);
    src_det = 1; @(negedge clk); @(negedge clk);
    chk(ee_req, "R1 start on source detect", ee_req, 1);
    repeat (100) @(negedge clk);
    chk(hpd == 4'h0, "R3 hpd low during copy", hpd, 0);
    wait_ready(3000);
    chk(edid_ready && hpd == 4'hF, "R3 ready hpd", hpd, 4'hF);
    local_pwr = 1;

    for (int v = 0; v < 5; v++) begin
      logic [28:0] e;
      e = VEC[v];
      build(e[28:21], e[20], e[19], int'(e[18:11]));
      restart();
      wait_ready(3000);
      chk(edid_ready, "R10 rerun after restart", edid_ready, 1);
      chk(seq_bad == 0 && acks == 256, "R2 address order", acks, 256);
      chk(blk_ok == e[10:9], "R4 block sums", blk_ok, e[10:9]);
      chk(pa_found == e[8], "R5 found", pa_found, e[8]);
      chk(pa_ptr == e[7:0], "R5 pointer", pa_ptr, e[7:0]);
      for (int k = 0; k < 4; k++) begin
        int a;
        a = (k == 0) ? 0 : (k == 1) ? 127 : (k == 2) ? 200 : 255;
        rd_addr = AW'(a); #1;
        chk(rd_data == eimg[a], "R2 R6 stored byte", rd_data, eimg[a]);
      end
    end

    rd_dev = 8'hA2; #1;
    chk(rd_data == 8'hFF, "R6 wrong device", rd_data, 8'hFF);
    rd_dev = 8'hA0;

    // R10 ignored without local power
    local_pwr = 0; restart_n = 0; repeat (5) @(negedge clk); restart_n = 1;
    repeat (2) @(negedge clk);
    chk(edid_ready && hpd == 4'hF, "R10 restart ignored", edid_ready, 1);
    local_pwr = 1;

    // R9 odd mode value ignored
    mode(8'h05); repeat (3) @(negedge clk);
    chk(edid_ready, "R9 mode 0x05 ignored", edid_ready, 1);

    // R7 timeout
    ee_dead = 1; restart();
    repeat (TMO + 20) @(negedge clk);
    chk(ee_err, "R7 err set", ee_err, 1);
    chk(!ee_req && hpd == 4'h0 && !edid_ready, "R7 hold low", hpd, 0);
    ee_dead = 0; restart(); @(negedge clk);
    chk(!ee_err, "R10 err cleared", ee_err, 0);
    wait_ready(3000);
    chk(edid_ready, "R7 recover", edid_ready, 1);

    // R8 disable
    repl_en = 0; @(negedge clk);
    chk(hpd == 4'hF && !edid_ready && !ee_req && rd_data == 8'hFF, "R8 disabled", hpd, 4'hF);
    repeat (10) @(negedge clk);
    chk(!ee_req && !edid_ready, "R8 stays off", ee_req, 0);
    exp_next = 0; seq_bad = 0; acks = 0;
    repl_en = 1; @(negedge clk); @(negedge clk);
    chk(ee_req && hpd == 4'h0, "R8 rerun on enable", ee_req, 1);
    wait_ready(3000);
    chk(edid_ready && acks == 256, "R8 rerun complete", acks, 256);

    // R9 external load
    mode(8'h01); @(negedge clk);
    chk(!edid_ready && hpd == 4'h0 && !ee_req, "R9 ext mode holds", hpd, 0);
    build(8'd17, 0, 1, 130);
    acks = 0;
    for (int a = 0; a < 256; a++) begin
      ext_we = 1; ext_addr = AW'(a); ext_wdata = eimg[a]; @(negedge clk);
    end
    ext_we = 0;
    repeat (20) @(negedge clk);
    chk(!edid_ready && hpd == 4'h0, "R9 held until 0x00", hpd, 0);
    mode(8'h00);
    wait_ready(1000);
    chk(edid_ready && acks == 0, "R9 ready without EEPROM", acks, 0);
    chk(blk_ok == 2'b10, "R9 R4 ext sums", blk_ok, 2'b10);
    chk(pa_found && pa_ptr == 8'd133, "R9 R5 ext pointer", pa_ptr, 133);
    rd_addr = 8'd131; #1;
    chk(rd_data == 8'h0C, "R9 R6 ext byte", rd_data, 8'h0C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule